// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Controller

This block is the digital part of a fractional-N synthesizer's feedback path. A programmable counter counts VCO-side clock events (`vco_tick`) and produces one feedback pulse each time a period ends. Each period lasts either N or N+1 events. A 20-bit phase accumulator picks between them once per feedback period. The long-run average divide ratio is therefore N + F/2^20. For example, a 27 MHz comparison rate and a 2170 MHz target need N = 80 and F = 388361.

A second counter divides reference events (`ref_tick`) by R and produces the comparison pulse. Software presents new N, F, fractional-enable and R values together with a one-cycle load strobe. The block holds them in a shadow set and adopts them at the next feedback boundary, so a period is never built from a partial update.

Both event inputs are clock enables sampled on the single block clock. The phase detector, charge pump, loop filter and any higher-order noise shaping sit outside this block.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Each feedback period lasts exactly the selected modulus counted in `vco_tick` events. `fb_pulse` is high for exactly the one clock cycle that follows the clock edge on which the period's last event was sampled.
- R2: With fractional mode on, each feedback boundary adds F to a 20-bit accumulator. The period that starts there has modulus N+1 if that addition carries past 2^20, and N otherwise. Over 2^k periods with F = 2^(20-k), the average ratio is N + F/2^20.
- R3: With fractional mode off, every period has modulus N, F has no effect, and the accumulator is cleared at each boundary.
- R4: An N value below 19 is used as 19, and an N value above 251 is used as 251.
- R5: `cmp_pulse` is high for one cycle after every R-th `ref_tick` event. An R value of 0 is used as 1.
- R6: Values captured with `cfg_load` take effect only at the next feedback boundary. The period in progress, and the R used by the reference divider, keep their old values until that boundary.
- R7: After reset the outputs are low, and the block behaves as if N = 35, F = 194180, fractional mode is on and R = 1, with the accumulator at zero. This gives six periods of 35 events and then one of 36.
- R8: Clock cycles without `vco_tick` do not advance the feedback counter and produce no feedback pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One VCO-side divider event per high cycle |
| ref_tick | input | 1 | One reference clock event per high cycle |
| cfg_load | input | 1 | Captures the cfg_* values into the shadow set |
| cfg_n | input | 15 | Integer divide value N |
| cfg_f | input | 20 | Fraction F, weight 2^-20 |
| cfg_frac_en | input | 1 | 1 = fractional mode on |
| cfg_r | input | 5 | Reference divide value R |
| fb_pulse | output | 1 | Feedback pulse, one per divided period |
| cmp_pulse | output | 1 | Comparison pulse, one per R reference events |

## Verification
The in-module assertions check several properties on every cycle:
- feedback and comparison pulses only ever follow a sampled event;
- the feedback count stays frozen when no VCO event arrives;
- the active N stays inside the clamped range;
- the configuration changes only at a feedback boundary;
- the accumulator wraps below F on a carry and is cleared in integer mode.

Other behaviour is visible only through the bench's scenarios, which measure period lengths at the pins against a behavioural model:
- the exact N/N+1 sequence and the average ratio for a given fraction;
- that a load leaves the running period untouched;
- the reset-default period pattern;
- the R divide ratio.

// File: rtl/fracn_div_pkg.sv
// Shared constants and types for the fractional-N divide-ratio controller.
// Assumes the integer divide value never exceeds 251, so 8 bits hold it.
package fracn_div_pkg;
    parameter int N_W    = 15;       // width of the programmed integer value
    parameter int F_W    = 20;       // width of the fraction
    parameter int R_W    = 5;        // width of the reference divide value
    parameter int N_LO   = 19;       // smallest usable integer ratio
    parameter int N_HI   = 251;      // largest usable integer ratio
    parameter int CNT_W  = 8;        // holds N_HI + 1
    parameter int N_DEF  = 35;       // reset integer value
    parameter int F_DEF  = 194180;   // reset fraction
    parameter int R_DEF  = 1;        // reset reference divide

    typedef struct packed {
        logic [CNT_W-1:0] n;
        logic [F_W-1:0]   f;
        logic             frac;
        logic [R_W-1:0]   r;
    } ratio_cfg_t;

    // Restricts a programmed integer value to the usable range.
    function automatic logic [CNT_W-1:0] clamp_n(input logic [N_W-1:0] v);
        if (v < N_W'(N_LO))
            return CNT_W'(N_LO);
        else if (v > N_W'(N_HI))
            return CNT_W'(N_HI);
        else
            return v[CNT_W-1:0];
    endfunction

    // Maps a zero reference divide onto divide-by-one.
    function automatic logic [R_W-1:0] clamp_r(input logic [R_W-1:0] v);
        return (v == '0) ? R_W'(1) : v;
    endfunction
endpackage

// File: rtl/fracn_cfg_shadow.sv
// Holds the pending (shadow) ratio set and the active set.
// A load strobe fills the shadow set. The active set is replaced only on a
// feedback boundary. `eff` is the set that governs the period starting at the
// current boundary.
// Assumes `boundary` is a single-cycle strobe from the feedback counter.
module fracn_cfg_shadow
    import fracn_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_W-1:0]   n_in,
    input  logic [F_W-1:0]   f_in,
    input  logic             frac_in,
    input  logic [R_W-1:0]   r_in,
    input  logic             boundary,
    output ratio_cfg_t       eff,
    output ratio_cfg_t       active
);
    ratio_cfg_t shadow;
    logic       pend;

    // Capture clamped values into the shadow set and flag them as pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '{n: CNT_W'(N_DEF), f: F_W'(F_DEF), frac: 1'b1, r: R_W'(R_DEF)};
            pend   <= 1'b0;
        end else if (load) begin
            shadow <= '{n: clamp_n(n_in), f: f_in, frac: frac_in, r: clamp_r(r_in)};
            pend   <= 1'b1;
        end else if (boundary) begin
            pend   <= 1'b0;
        end
    end

    // Adopt the pending set at a feedback boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '{n: CNT_W'(N_DEF), f: F_W'(F_DEF), frac: 1'b1, r: R_W'(R_DEF)};
        else if (boundary && pend)
            active <= shadow;
    end

    // Select the set that governs the next period.
    always_comb eff = pend ? shadow : active;

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active));
    assert_cfg_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && pend && !load) |=> (active == $past(shadow)));
    assert_n_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active.n >= CNT_W'(N_LO)) && (active.n <= CNT_W'(N_HI)));
    assert_r_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active.r != '0);
endmodule

// File: rtl/fracn_phase_acc.sv
// First-order phase accumulator. On every step it adds the fraction and
// reports the carry out of bit F_W-1, which selects modulus N+1.
// In integer mode it reports no carry and clears itself.
module fracn_phase_acc
    import fracn_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           frac_en,
    input  logic [F_W-1:0] f,
    output logic           carry
);
    logic [F_W-1:0] acc;
    logic [F_W:0]   sum;

    // Form the sum and the carry for the step taken this cycle.
    always_comb begin
        sum   = {1'b0, acc} + {1'b0, f};
        carry = frac_en & sum[F_W];
    end

    // Advance the phase on a step; clear it when fractional mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (step)
            acc <= frac_en ? sum[F_W-1:0] : '0;
    end

    assert_acc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !frac_en) |=> (acc == '0));
    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && carry) |=> (acc < $past(f)));
    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc));
endmodule

// File: rtl/fracn_mod_counter.sv
// Programmable down-counter over VCO-side events. It ends a period on the
// event that finds the count at zero, reloads with (modulus - 1), and
// registers a one-cycle feedback pulse.
// Assumes the modulus lies within N_LO .. N_HI+1.
module fracn_mod_counter
    import fracn_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] modulus,
    output logic             boundary,
    output logic             fb_pulse
);
    logic [CNT_W-1:0] cnt;

    // Detect the last event of the running period.
    always_comb boundary = tick && (cnt == '0);

    // Count events down and reload at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(N_DEF - 1);
        else if (boundary)
            cnt <= modulus - CNT_W'(1);
        else if (tick)
            cnt <= cnt - CNT_W'(1);
    end

    // Register the feedback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fb_pulse <= 1'b0;
        else
            fb_pulse <= boundary;
    end

    assert_fb_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(tick));
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && !fb_pulse));
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(N_HI));
endmodule

// File: rtl/fracn_ref_div.sv
// Reference divider: one comparison pulse per r_div reference events.
// It reads r_div only when it reloads.
// Assumes r_div is never zero; the shadow logic maps zero to one.
module fracn_ref_div
    import fracn_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [R_W-1:0] r_div,
    output logic           cmp_pulse
);
    logic [R_W-1:0] rcnt;

    // Count reference events down and reload after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt <= '0;
        else if (tick)
            rcnt <= (rcnt == '0) ? r_div - R_W'(1) : rcnt - R_W'(1);
    end

    // Register the comparison pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_pulse <= 1'b0;
        else
            cmp_pulse <= tick && (rcnt == '0);
    end

    assert_cmp_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |-> $past(tick));
    assert_cmp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rcnt != '0) |=> !cmp_pulse);
endmodule

// File: rtl/fracn_div_ctrl.sv
// Top of the fractional-N divide-ratio controller. It joins the shadow
// configuration, the phase accumulator, the modulus counter and the
// reference divider. The modulus of each new period is the effective N plus
// the accumulator carry taken at the same boundary.
// Assumes vco_tick and ref_tick are single-cycle enables on clk.
module fracn_div_ctrl
    import fracn_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           cfg_load,
    input  logic [N_W-1:0] cfg_n,
    input  logic [F_W-1:0] cfg_f,
    input  logic           cfg_frac_en,
    input  logic [R_W-1:0] cfg_r,
    output logic           fb_pulse,
    output logic           cmp_pulse
);
    ratio_cfg_t       eff;
    ratio_cfg_t       active;
    logic             boundary;
    logic             carry;
    logic [CNT_W-1:0] modulus;

    // Choose N or N+1 for the period that starts at this boundary.
    always_comb modulus = eff.n + CNT_W'(carry);

    fracn_cfg_shadow u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .n_in     (cfg_n),
        .f_in     (cfg_f),
        .frac_in  (cfg_frac_en),
        .r_in     (cfg_r),
        .boundary (boundary),
        .eff      (eff),
        .active   (active)
    );

    fracn_phase_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (boundary),
        .frac_en (eff.frac),
        .f       (eff.f),
        .carry   (carry)
    );

    fracn_mod_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (vco_tick),
        .modulus  (modulus),
        .boundary (boundary),
        .fb_pulse (fb_pulse)
    );

    fracn_ref_div u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ref_tick),
        .r_div     (active.r),
        .cmp_pulse (cmp_pulse)
    );

    assert_modulus_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> ((modulus >= CNT_W'(N_LO)) && (modulus <= CNT_W'(N_HI + 1))));
endmodule

// File: tb/fracn_div_ctrl_test.sv
module fracn_div_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        cfg_load = 1'b0;
    logic [14:0] cfg_n = '0;
    logic [19:0] cfg_f = '0;
    logic        cfg_frac_en = 1'b0;
    logic [4:0]  cfg_r = '0;
    logic        fb_pulse;
    logic        cmp_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int vmode = 1;      // 0 none, 1 every cycle, 2 pseudo-random
    int rmode = 0;      // 0 none, 1 every cycle
    logic [7:0] lfsr = 8'hA5;

    // Behavioural model state
    int      mcnt, an, afr, ar, sn, sfr, sr, rc, ticks, rticks;
    longint  macc, af, sf;
    bit      pend;
    bit      efb = 1'b0;
    bit      ecmp = 1'b0;
    int      periods[$];
    int      rperiods[$];

    fracn_div_ctrl uut (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .cfg_load(cfg_load), .cfg_n(cfg_n), .cfg_f(cfg_f),
        .cfg_frac_en(cfg_frac_en), .cfg_r(cfg_r),
        .fb_pulse(fb_pulse), .cmp_pulse(cmp_pulse)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int clampn(input int v);
        if (v < 19) return 19;
        if (v > 251) return 251;
        return v;
    endfunction

    // Event stimulus, changed away from the sampling edge
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        vco_tick <= (vmode == 1) || (vmode == 2 && (lfsr[0] | lfsr[1]));
        ref_tick <= (rmode == 1);
    end

    // Reference model, stepped on each active edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mcnt = 34; macc = 0; an = 35; af = 194180; afr = 1; ar = 1;
            sn = 35; sf = 194180; sfr = 1; sr = 1; pend = 0; rc = 0;
            efb = 0; ecmp = 0; ticks = 0; rticks = 0;
        end else begin
            bit term;
            int en, efr, er;
            longint ef, sum;
            int c;
            if (fb_pulse) begin periods.push_back(ticks); ticks = 0; end
            if (cmp_pulse) begin rperiods.push_back(rticks); rticks = 0; end
            if (vco_tick) ticks++;
            if (ref_tick) rticks++;
            term = vco_tick && mcnt == 0;
            ecmp = ref_tick && rc == 0;
            if (ref_tick) rc = (rc == 0) ? ar - 1 : rc - 1;
            if (term) begin
                en = pend ? sn : an; ef = pend ? sf : af;
                efr = pend ? sfr : afr; er = pend ? sr : ar;
                c = 0;
                if (efr != 0) begin
                    sum = macc + ef;
                    if (sum >= 1048576) begin c = 1; sum = sum - 1048576; end
                    macc = sum;
                end else macc = 0;
                mcnt = en + c - 1;
                an = en; af = ef; afr = efr; ar = er;
            end else if (vco_tick) mcnt--;
            if (cfg_load) begin
                sn = clampn(int'(cfg_n)); sf = cfg_f; sfr = cfg_frac_en;
                sr = (cfg_r == 0) ? 1 : int'(cfg_r); pend = 1;
            end else if (term) pend = 0;
            efb = term;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(fb_pulse == efb, "R1 fb_pulse vs model", fb_pulse, efb);
            chk(cmp_pulse == ecmp, "R5 cmp_pulse vs model", cmp_pulse, ecmp);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(fb_pulse == 1'b0, "R7 fb_pulse in reset", fb_pulse, 0);
        chk(cmp_pulse == 1'b0, "R7 cmp_pulse in reset", cmp_pulse, 0);
        periods.delete();
        rperiods.delete();
        rst_n = 1'b1;
    endtask

    task automatic load(input int n, input int f, input bit fr, input int r);
        @(negedge clk);
        cfg_n = 15'(n); cfg_f = 20'(f); cfg_frac_en = fr; cfg_r = 5'(r); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_periods(input int k);
        while (periods.size() < k) @(negedge clk);
    endtask

    initial begin
        int s;
        // R7: defaults give six periods of 35 and then one of 36
        vmode = 1; rmode = 1;
        do_reset();
        wait_periods(7);
        for (int i = 0; i < 6; i++) chk(periods[i] == 35, "R7 default period", periods[i], 35);
        chk(periods[6] == 36, "R7 R2 default carry period", periods[6], 36);
        chk(rperiods[2] == 1, "R5 R7 default R of one", rperiods[2], 1);

        // R6 and R2: load during the first period; half fraction alternates 40/41
        do_reset();
        repeat (5) @(negedge clk);
        load(40, 524288, 1'b1, 1);
        wait_periods(9);
        chk(periods[0] == 35, "R6 running period kept", periods[0], 35);
        chk(periods[1] == 40, "R2 first new period", periods[1], 40);
        chk(periods[2] == 41, "R2 carry period", periods[2], 41);
        s = 0;
        for (int i = 1; i < 9; i++) s += periods[i];
        chk(s == 324, "R2 average ratio 40.5 over 8", s, 324);

        // R2: a 2170 MHz target from a 27 MHz comparison, N=80, F=388361
        do_reset();
        load(80, 388361, 1'b1, 1);
        wait_periods(9);
        chk(periods[3] == 81, "R2 worked example carry", periods[3], 81);
        s = 0;
        for (int i = 1; i < 9; i++) s += periods[i];
        chk(s == 642, "R2 worked example sum", s, 642);

        // R3: fractional mode off ignores F
        do_reset();
        load(50, 524288, 1'b0, 1);
        wait_periods(4);
        for (int i = 1; i < 4; i++) chk(periods[i] == 50, "R3 integer mode period", periods[i], 50);

        // R4: clamping at both ends
        do_reset();
        load(5, 0, 1'b0, 1);
        wait_periods(3);
        chk(periods[2] == 19, "R4 low clamp", periods[2], 19);
        load(300, 0, 1'b0, 1);
        wait_periods(6);
        chk(periods[5] == 251, "R4 high clamp", periods[5], 251);

        // R5 and R6: R of 3 applies after the boundary; R of 0 acts as 1
        do_reset();
        load(20, 0, 1'b0, 3);
        repeat (10) @(negedge clk);
        chk(rperiods[rperiods.size()-1] == 1, "R6 R held until boundary", rperiods[rperiods.size()-1], 1);
        wait_periods(3);
        chk(rperiods[rperiods.size()-1] == 3, "R5 divide by three", rperiods[rperiods.size()-1], 3);
        load(20, 0, 1'b0, 0);
        s = periods.size();
        wait_periods(s + 2);
        repeat (3) @(negedge clk);
        chk(rperiods[rperiods.size()-1] == 1, "R5 zero acts as one", rperiods[rperiods.size()-1], 1);

        // R8 and R1: gaps in vco_tick
        do_reset();
        load(25, 0, 1'b0, 1);
        vmode = 2;
        wait_periods(4);
        chk(periods[2] == 25, "R1 R8 period counted in events", periods[2], 25);
        vmode = 0;
        repeat (2) @(negedge clk);
        s = periods.size();
        repeat (100) @(negedge clk);
        chk(periods.size() == s, "R8 no pulse without events", periods.size(), s);
        vmode = 1;
        repeat (60) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule